// File: doc/BRIEF.md
# Architectural State Save/Restore Register Bank

This block holds every piece of accelerator-defined architectural state as one flat, indexed array of 64-bit generic registers. Whatever instruction set is loaded onto the accelerator, its visible state lives in this array. As a result, a single operating-system routine can save and restore the state of any loaded instruction set. The routine first asks how many registers exist. It then walks the indices: it copies each register out to a scalar register to save it, or loads each one from a scalar register to restore it.

Commands enter on a valid/ready channel and carry an operation code, an index and a 64-bit data word. The pipeline supplies a count of instructions still in flight. A command of any kind is held off while that count is non-zero, so the state is only read or written at an instruction boundary. Each accepted command produces exactly one response strobe on the following cycle. The response carries a data word and an error flag.

Top module: `ctx_state_bank`

## Requirements
- R1: After reset, `rspValid` and `rspErr` are low, and every register reads back as zero.
- R2: `cmdReady` is high exactly when `pendCount` is zero. While `pendCount` is non-zero, a presented command is neither executed nor answered, and it is accepted in the first cycle the count reads zero.
- R3: Operation code 2'b00 (count) returns `NUM_REGS` on `rspData`, with `rspErr` low.
- R4: Every accepted command raises `rspValid` for exactly one cycle, on the cycle after the command is accepted. Without an acceptance, `rspValid` stays low.
- R5: Operation code 2'b01 (save) with an index below `NUM_REGS` returns the content of that register, with `rspErr` low.
- R6: Operation code 2'b10 (restore) with an index below `NUM_REGS` writes `cmdData` into that register. It responds with data zero and `rspErr` low. A save accepted on the very next cycle already sees the new value.
- R7: A save with an index at or above `NUM_REGS` returns data zero with `rspErr` high.
- R8: A restore with an index at or above `NUM_REGS` changes no register and responds with `rspErr` high.
- R9: Operation code 2'b11 is reserved. It changes no register and responds with data zero and `rspErr` high.
- R10: Whenever `rspValid` is low, `rspData` is zero and `rspErr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is presented |
| cmdReady | output | 1 | The command is accepted this cycle (pipeline drained) |
| cmdOp | input | 2 | 00 count, 01 save, 10 restore, 11 reserved |
| cmdIndex | input | IDX_W | Generic register index |
| cmdData | input | 64 | Data to write for a restore |
| pendCount | input | PEND_W | Number of instructions still in flight |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 64 | Count value or saved register contents |
| rspErr | output | 1 | Index out of range, or reserved operation |

## Verification
Two functions can fall in the same cycle: the pipeline draining, which releases a held command, and the execution of that command. The bench provokes this by presenting a restore while it counts `pendCount` down one step per cycle. It judges the result by the number of cycles without a response, which must equal the starting count. It also requires the response exactly one cycle after the count reaches zero. A second overlap is a restore followed on the next cycle by a save of the same index. The bench walks the full array this way, once to save and once to restore, with in-flight activity inserted before most commands. It then compares every register against the saved image after the array has been deliberately corrupted.

// File: rtl/ctx_bank_pkg.sv
package ctx_bank_pkg;

  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    OP_COUNT   = 2'b00,
    OP_SAVE    = 2'b01,
    OP_RESTORE = 2'b10,
    OP_RSVD    = 2'b11
  } bankOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // write the addressed register
    logic rdEn;    // capture the addressed register into the response
    logic cntEn;   // capture the register count into the response
    logic rspEn;   // a command is accepted this cycle
  } bankCtl_t;

endpackage

// File: rtl/ctx_bank_ctrl.sv
module ctx_bank_ctrl
  import ctx_bank_pkg::*;
#(
  parameter int NUM_REGS = 20,
  parameter int IDX_W    = 6,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [PEND_W-1:0] pendCount,
  output logic              cmdReady,
  output bankCtl_t          ctl,
  output logic              rspValid,
  output logic              rspErr
);

  bankOp_e op;
  logic    drained;
  logic    accept;
  logic    inRange;
  logic    errNext;

  assign op      = bankOp_e'(cmdOp);
  assign drained = (pendCount == '0);
  assign accept  = cmdValid && drained;
  assign inRange = (int'(cmdIndex) < NUM_REGS);

  assign cmdReady = drained;

  always_comb begin
    ctl       = '0;
    ctl.rspEn = accept;
    errNext   = 1'b0;
    if (accept) begin
      unique case (op)
        OP_COUNT:   ctl.cntEn = 1'b1;
        OP_SAVE:    begin ctl.rdEn = inRange; errNext = !inRange; end
        OP_RESTORE: begin ctl.wrEn = inRange; errNext = !inRange; end
        default:    errNext = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= accept;
      rspErr   <= errNext;
    end
  end

endmodule

// File: rtl/ctx_bank_dp.sv
module ctx_bank_dp
  import ctx_bank_pkg::*;
#(
  parameter int NUM_REGS = 20,
  parameter int IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankCtl_t          ctl,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [WORD_W-1:0] cmdData,
  output logic [WORD_W-1:0] rspData
);

  logic [WORD_W-1:0] regFile [NUM_REGS];
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] rspNext;

  // one write-enabled register per generic slot
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (ctl.wrEn && (cmdIndex == IDX_W'(g)))
        regFile[g] <= cmdData;
    end
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (cmdIndex == IDX_W'(i)) rdWord = regFile[i];
  end

  always_comb begin
    rspNext = '0;
    if (ctl.cntEn)     rspNext = WORD_W'(NUM_REGS);
    else if (ctl.rdEn) rspNext = rdWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspData <= '0;
    else       rspData <= ctl.rspEn ? rspNext : '0;
  end

endmodule

// File: rtl/ctx_state_bank.sv
module ctx_state_bank
  import ctx_bank_pkg::*;
#(
  parameter int NUM_REGS = 20,
  parameter int IDX_W    = 6,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [63:0]       cmdData,
  input  logic [PEND_W-1:0] pendCount,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              rspErr
);

  bankCtl_t ctl;

  ctx_bank_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .PEND_W(PEND_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIndex(cmdIndex), .pendCount(pendCount), .cmdReady(cmdReady),
    .ctl(ctl), .rspValid(rspValid), .rspErr(rspErr)
  );

  ctx_bank_dp #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdIndex(cmdIndex),
    .cmdData(cmdData), .rspData(rspData)
  );

endmodule

// File: rtl/ctx_bank_chk.sv
module ctx_bank_chk #(
  parameter int NUM_REGS = 20,
  parameter int IDX_W    = 6,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdOp,
  input logic [IDX_W-1:0]  cmdIndex,
  input logic [PEND_W-1:0] pendCount,
  input logic              rspValid,
  input logic [63:0]       rspData,
  input logic              rspErr
);

  logic accept;
  assign accept = cmdValid && cmdReady;

  p_stall_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount != '0) |-> !cmdReady);

  p_no_answer_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount != '0) |=> !rspValid);

  p_rsp_next_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);

  p_rsp_only_on_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);

  p_count_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'b00) |=> (rspData == 64'(NUM_REGS) && !rspErr));

  p_oob_save_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'b01 && int'(cmdIndex) >= NUM_REGS) |=> (rspData == '0 && rspErr));

  p_oob_restore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'b10 && int'(cmdIndex) >= NUM_REGS) |=> rspErr);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'b11) |=> (rspData == '0 && rspErr));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspData == '0 && !rspErr));

endmodule

bind ctx_state_bank ctx_bank_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdOp(cmdOp), .cmdIndex(cmdIndex), .pendCount(pendCount),
  .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
);

// File: tb/test_ctx_state_bank.sv
module test_ctx_state_bank;

  localparam int NREG = 20;
  localparam int IW   = 6;
  localparam int PW   = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [1:0]    cmdOp = '0;
  logic [IW-1:0] cmdIndex = '0;
  logic [63:0]   cmdData = '0;
  logic [PW-1:0] pendCount = '0;
  logic          rspValid;
  logic [63:0]   rspData;
  logic          rspErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ctx_state_bank #(.NUM_REGS(NREG), .IDX_W(IW), .PEND_W(PW)) i_ctx_state_bank (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdIndex(cmdIndex), .cmdData(cmdData),
    .pendCount(pendCount), .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
  );

  // op, index, data, expected data, expected error
  localparam int NVEC = 13;
  localparam logic [136:0] VECS [NVEC] = '{
    {2'b00, 6'd0,  64'h0,                 64'd20,                1'b0}, // R3
    {2'b10, 6'd0,  64'hA5A5_0001_DEAD_BEEF, 64'h0,               1'b0}, // R6
    {2'b10, 6'd19, 64'h1234_5678_9ABC_DEF0, 64'h0,               1'b0}, // R6
    {2'b01, 6'd0,  64'h0,  64'hA5A5_0001_DEAD_BEEF,              1'b0}, // R5
    {2'b01, 6'd19, 64'h0,  64'h1234_5678_9ABC_DEF0,              1'b0}, // R5
    {2'b01, 6'd1,  64'h0,                 64'h0,                 1'b0}, // R1
    {2'b01, 6'd20, 64'h0,                 64'h0,                 1'b1}, // R7
    {2'b10, 6'd20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,               1'b1}, // R8
    {2'b01, 6'd63, 64'h0,                 64'h0,                 1'b1}, // R7
    {2'b11, 6'd0,  64'h0BAD_0BAD_0BAD_0BAD, 64'h0,               1'b1}, // R9
    {2'b01, 6'd0,  64'h0,  64'hA5A5_0001_DEAD_BEEF,              1'b0}, // R9
    {2'b10, 6'd0,  64'h7777_0000_1111_2222, 64'h0,               1'b0}, // R6
    {2'b01, 6'd0,  64'h0,  64'h7777_0000_1111_2222,              1'b0}  // R6
  };

  function automatic string vecTag(int i);
    case (i)
      0:          return "R3";
      1, 2, 11, 12: return "R6";
      3, 4:       return "R5";
      5:          return "R1";
      6, 8:       return "R7";
      7:          return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Presents a command with 'busy' instructions in flight, draining one per cycle.
  task automatic issue(input logic [1:0] op, input int idx, input logic [63:0] d,
                       input int busy, output logic [63:0] rd, output logic er);
    int stallCycles = 0;
    bit earlyRsp = 1'b0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdIndex = IW'(idx); cmdData = d;
    pendCount = PW'(busy);
    #1;
    while (!cmdReady) begin
      @(negedge clk);
      if (rspValid) earlyRsp = 1'b1;
      stallCycles++;
      pendCount = pendCount - 1'b1;
      #1;
    end
    if (busy != 0) begin
      check(!earlyRsp, "R2 no response while busy", 64'(earlyRsp), 64'd0);
      check(stallCycles == busy, "R2 stall length", 64'(stallCycles), 64'(busy));
    end
    @(negedge clk);
    check(rspValid, "R4 response one cycle after accept", 64'(rspValid), 64'd1);
    rd = rspData; er = rspErr;
    cmdValid = 1'b0;
    #1;
    @(negedge clk);
    check(!rspValid, "R4 single-cycle strobe", 64'(rspValid), 64'd0);
    check(rspData == '0 && !rspErr, "R10 idle response quiet", rspData, 64'd0);
  endtask

  logic [63:0] saved [NREG];
  logic [63:0] rd;
  logic        er;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!rspValid && !rspErr && rspData == '0, "R1 reset outputs", rspData, 64'd0);
    check(cmdReady, "R2 ready when drained", 64'(cmdReady), 64'd1);

    // table-driven vectors
    for (int v = 0; v < NVEC; v++) begin
      logic [136:0] e;
      e = VECS[v];
      issue(e[136:135], int'(e[134:129]), e[128:65], v % 3, rd, er);
      check(rd == e[64:1] && er == e[0], vecTag(v), rd, e[64:1]);
    end

    // fill all registers with a pattern
    for (int i = 0; i < NREG; i++) begin
      issue(2'b10, i, {32'hC0DE_0000 + 32'(i), ~32'(i * 7)}, i % 4, rd, er);
      check(!er, "R6 in-range restore", 64'(er), 64'd0);
    end
    // restore of an out-of-range index must leave all of them alone
    issue(2'b10, 40, 64'hDEAD, 2, rd, er);
    check(er, "R8 out-of-range restore flagged", 64'(er), 64'd1);
    // save all (with pipeline activity)
    for (int i = 0; i < NREG; i++) begin
      issue(2'b01, i, 64'h0, (i + 1) % 5, rd, er);
      saved[i] = rd;
      check(rd == {32'hC0DE_0000 + 32'(i), ~32'(i * 7)}, "R5 R8 save matches", rd,
            {32'hC0DE_0000 + 32'(i), ~32'(i * 7)});
    end
    // corrupt
    for (int i = 0; i < NREG; i++) issue(2'b10, i, 64'hFFFF_0000_FFFF_0000 ^ 64'(i), 0, rd, er);
    issue(2'b01, 3, 64'h0, 0, rd, er);
    check(rd == (64'hFFFF_0000_FFFF_0000 ^ 64'd3), "R6 corruption visible", rd,
          64'hFFFF_0000_FFFF_0000 ^ 64'd3);
    // restore then immediate read-back of each index
    for (int i = 0; i < NREG; i++) begin
      issue(2'b10, i, saved[i], (i + 2) % 4, rd, er);
      issue(2'b01, i, 64'h0, 0, rd, er);
      check(rd == saved[i], "R6 restore then save", rd, saved[i]);
    end

    // long stall released in the same cycle the count reaches zero
    issue(2'b00, 0, 64'h0, 15, rd, er);
    check(rd == 64'(NREG) && !er, "R3 R2 count after long stall", rd, 64'(NREG));

    // reset clears contents
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    issue(2'b01, 7, 64'h0, 0, rd, er);
    check(rd == '0 && !er, "R1 cleared after reset", rd, 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule